// File: doc/BRIEF.md
# Subperiod-Sequenced Counting Digitizer Controller

This block runs the digital side of a counting analog-to-digital converter. The converter resolves one decimal digit in each subperiod. A one-hot sequencer moves through an idle zero phase and then five digit phases, named A to E. An external subperiod tick moves it forward one phase at a time.

In each digit phase a gated pulse counter starts from zero and adds one for every oscillator pulse. The count is re-coded into the 4-4-2-1 weighting of the resistor ladder, so the ladder voltage rises with the count. The counter stops when the synchronised comparator reports balance, or when it reaches the ceiling for that phase. The ceiling is 11 for the leading digit and 9 for the later digits. The count then holds until the next tick. At that tick the finished digit is presented with a one-cycle strobe, its phase index and its value, so that display storage can capture it.

Top module: `subperiod_digitizer_ctrl`

## Requirements
- R1: `phase_onehot` has exactly one bit set: bit 0 is ZERO and bits 1 to 5 are phases A to E. Each cycle with `sub_tick` high moves it one phase in the order ZERO, A, B, C, D, E, and after E it returns to ZERO.
- R2: While `counting` is high, `count_bin` rises by exactly one in each cycle in which `osc_pulse` is high and the synchronised comparator is low. In every other cycle without a tick it keeps its value.
- R3: A cycle with `sub_tick` high clears `count_bin` to 0 on the next edge. On the same edge `counting` becomes 1 if the new phase is A to E, and 0 if the new phase is ZERO.
- R4: In phase A the count stops at 11: on reaching 11, `counting` drops and further pulses are ignored.
- R5: In phases B to E the count stops at 9: on reaching 9, `counting` drops and further pulses are ignored.
- R6: In phase ZERO no pulse is counted, and `count_bin` stays 0.
- R7: `ladder_code` is {c3, c3|c2, c1, c0} of `count_bin` = {c3,c2,c1,c0}. With bit weights 4, 4, 2 and 1 it sums to the count, for every count from 0 to 11.
- R8: A tick that ends a digit phase raises `digit_valid` for exactly the following cycle. In that cycle `digit_idx` gives the finished phase (A=0 up to E=4), and `digit_val` gives the count held when the phase ended. A tick that ends phase ZERO raises no strobe.
- R9: `cmp_raw` passes through two flip-flops. A level driven before edge k first blocks counting in the cycle after edge k+1, and `counting` falls on edge k+2.
- R10: A synchronous active-high `rst` returns the block to phase ZERO, with the count at 0, `counting` low and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Advance to the next subperiod (one cycle) |
| osc_pulse | input | 1 | One oscillator pulse per cycle while high |
| cmp_raw | input | 1 | Asynchronous comparator balance input |
| phase_onehot | output | 6 | Current phase, one-hot, bit 0 = ZERO |
| counting | output | 1 | Counter enable flip-flop |
| count_bin | output | 4 | Binary 8-4-2-1 count |
| ladder_code | output | 4 | 4-4-2-1 code driving the ladder |
| digit_valid | output | 1 | One-cycle strobe for a finished digit |
| digit_idx | output | 3 | Finished phase index, A=0 to E=4 |
| digit_val | output | 4 | Finished digit count |

## Verification
Directed runs hold `osc_pulse` high through whole phases. This shows the ceiling of 11 in phase A apart from the ceiling of 9 in phases B to E, and shows that the idle zero phase never counts. A comparator trip in the middle of a count checks the two-cycle synchroniser delay exactly: a design that is one stage short or one stage long ends with a different held count. Seeded random ticks, gapped pulses and comparator bursts then mix phase changes with stops. This shows whether clear-on-tick overrides counting, and whether each strobe carries the count of the phase that just ended rather than the cleared one.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int CNT_W      = 4;
  localparam int NUM_PHASES = 6;
  localparam int IDX_W      = 3;

  // Re-code an 8-4-2-1 count into 4-4-2-1 ladder weighting (valid up to 11).
  function automatic logic [CNT_W-1:0] to_ladder(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] r;
    r[3] = c[3];
    r[2] = c[3] | c[2];
    r[1] = c[1];
    r[0] = c[0];
    return r;
  endfunction

  // Ceiling for the current phase: the leading digit has the larger limit.
  function automatic logic [CNT_W-1:0] phase_limit(input logic lead_phase,
                                                   input logic [CNT_W-1:0] lim_lead,
                                                   input logic [CNT_W-1:0] lim_rest);
    return lead_phase ? lim_lead : lim_rest;
  endfunction

  // Position of the set bit in a one-hot vector.
  function automatic logic [IDX_W-1:0] onehot_pos(input logic [NUM_PHASES-1:0] oh);
    logic [IDX_W-1:0] p;
    p = '0;
    for (int i = 0; i < NUM_PHASES; i++) begin
      if (oh[i]) p = IDX_W'(i);
    end
    return p;
  endfunction

endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdc_phase_seq.sv
module sdc_phase_seq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [N-1:0] phase_q,
  output logic         wrap_next
);
  // Ring shift register; a single stage is active per subperiod.
  always_ff @(posedge clk) begin
    if (rst)          phase_q <= N'(1);
    else if (advance) phase_q <= {phase_q[N-2:0], phase_q[N-1]};
  end

  // The next advance lands on ZERO when the last stage is active.
  assign wrap_next = phase_q[N-1];
endmodule

// File: rtl/sdc_pulse_counter.sv
module sdc_pulse_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         arm,
  input  logic         pulse,
  input  logic         stop,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count_q,
  output logic         enable_q,
  output logic         inc_event,
  output logic         limit_event,
  output logic         stop_event
);
  logic [W-1:0] count_plus;

  assign count_plus  = count_q + W'(1);
  assign stop_event  = enable_q & stop & ~clear;
  assign inc_event   = enable_q & pulse & ~stop & ~clear;
  assign limit_event = inc_event & (count_plus == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      enable_q <= 1'b0;
    end else if (clear) begin
      count_q  <= '0;
      enable_q <= arm;
    end else begin
      if (inc_event) count_q <= count_plus;
      if (stop_event || limit_event) enable_q <= 1'b0;
    end
  end
endmodule

// File: rtl/subperiod_digitizer_ctrl.sv
module subperiod_digitizer_ctrl
  import sdc_pkg::*;
#(
  parameter int LIMIT_LEAD  = 11,
  parameter int LIMIT_REST  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sub_tick,
  input  logic                  osc_pulse,
  input  logic                  cmp_raw,
  output logic [NUM_PHASES-1:0] phase_onehot,
  output logic                  counting,
  output logic [CNT_W-1:0]      count_bin,
  output logic [CNT_W-1:0]      ladder_code,
  output logic                  digit_valid,
  output logic [IDX_W-1:0]      digit_idx,
  output logic [CNT_W-1:0]      digit_val
);
  localparam logic [CNT_W-1:0] LIM_LEAD_C = CNT_W'(LIMIT_LEAD);
  localparam logic [CNT_W-1:0] LIM_REST_C = CNT_W'(LIMIT_REST);

  // Named internal events, visible to the bound checker.
  logic             cmp_sync;
  logic             wrap_next;
  logic             in_zero;
  logic             in_lead;
  logic             inc_event;
  logic             limit_event;
  logic             stop_event;
  logic             digit_done;
  logic [CNT_W-1:0] cur_limit;
  logic [IDX_W-1:0] phase_pos;

  sdc_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_raw),
    .q_sync  (cmp_sync)
  );

  sdc_phase_seq #(.N(NUM_PHASES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .advance   (sub_tick),
    .phase_q   (phase_onehot),
    .wrap_next (wrap_next)
  );

  assign in_zero    = phase_onehot[0];
  assign in_lead    = phase_onehot[1];
  assign cur_limit  = phase_limit(in_lead, LIM_LEAD_C, LIM_REST_C);
  assign phase_pos  = onehot_pos(phase_onehot);
  assign digit_done = sub_tick & ~in_zero;

  sdc_pulse_counter #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clear       (sub_tick),
    .arm         (~wrap_next),
    .pulse       (osc_pulse),
    .stop        (cmp_sync),
    .limit       (cur_limit),
    .count_q     (count_bin),
    .enable_q    (counting),
    .inc_event   (inc_event),
    .limit_event (limit_event),
    .stop_event  (stop_event)
  );

  assign ladder_code = to_ladder(count_bin);

  // Capture of the finished digit for display storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      digit_valid <= 1'b0;
      digit_idx   <= '0;
      digit_val   <= '0;
    end else begin
      digit_valid <= digit_done;
      if (digit_done) begin
        digit_idx <= phase_pos - IDX_W'(1);
        digit_val <= count_bin;
      end
    end
  end
endmodule

// File: rtl/subperiod_digitizer_ctrl_checker.sv
module subperiod_digitizer_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       sub_tick,
  input logic [5:0] phase_onehot,
  input logic       counting,
  input logic [3:0] count_bin,
  input logic [3:0] ladder_code,
  input logic       digit_valid,
  input logic       cmp_sync,
  input logic       inc_event
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_onehot) == 1); // R1

  AST_ADVANCE_ORDER: assert property (@(posedge clk) disable iff (rst)
    sub_tick && !phase_onehot[5] |=> phase_onehot == $past(phase_onehot) << 1); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sub_tick && !inc_event |=> $stable(count_bin)); // R2

  AST_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    sub_tick |=> count_bin == 4'd0); // R3

  AST_LEAD_CEILING: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[1] |-> count_bin <= 4'd11); // R4

  AST_REST_CEILING: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[5:2] != 4'b0) |-> count_bin <= 4'd9); // R5

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[0] |-> count_bin == 4'd0 && !counting); // R6

  AST_LADDER_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    4 * ladder_code[3] + 4 * ladder_code[2] + 2 * ladder_code[1] + ladder_code[0]
      == 32'(count_bin)); // R7

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    digit_valid |-> $past(sub_tick)); // R8

  AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (rst)
    counting && cmp_sync && !sub_tick |=> !counting); // R9
endmodule

bind subperiod_digitizer_ctrl subperiod_digitizer_ctrl_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .sub_tick     (sub_tick),
  .phase_onehot (phase_onehot),
  .counting     (counting),
  .count_bin    (count_bin),
  .ladder_code  (ladder_code),
  .digit_valid  (digit_valid),
  .cmp_sync     (cmp_sync),
  .inc_event    (inc_event)
);

// File: tb/subperiod_digitizer_ctrl_bench.sv
module subperiod_digitizer_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst, sub_tick, osc_pulse, cmp_raw;
  logic [5:0] phase_onehot;
  logic       counting, digit_valid;
  logic [3:0] count_bin, ladder_code, digit_val;
  logic [2:0] digit_idx;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  subperiod_digitizer_ctrl u_subperiod_digitizer_ctrl (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .osc_pulse(osc_pulse),
    .cmp_raw(cmp_raw), .phase_onehot(phase_onehot), .counting(counting),
    .count_bin(count_bin), .ladder_code(ladder_code), .digit_valid(digit_valid),
    .digit_idx(digit_idx), .digit_val(digit_val)
  );

  // Reference state, written from the requirements.
  int m_ph, m_cnt, m_idx, m_val;
  bit m_en, m_s1, m_s2, m_dv;

  function automatic int ceil_of(int ph);
    return (ph == 1) ? 11 : 9;
  endfunction

  function automatic logic [3:0] weigh(int c);
    logic [3:0] b;
    b = 4'(c);
    return {b[3], b[3] | b[2], b[1], b[0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 phase", int'(phase_onehot), 1 << m_ph);
    check("R2 count", int'(count_bin), m_cnt);
    check("R3 counting", int'(counting), int'(m_en));
    check("R7 ladder", int'(ladder_code), int'(weigh(m_cnt)));
    check("R8 strobe", int'(digit_valid), int'(m_dv));
    if (m_dv) begin
      check("R8 index", int'(digit_idx), m_idx);
      check("R8 value", int'(digit_val), m_val);
    end
  endtask

  task automatic model_step(bit r, bit t, bit o, bit c);
    int nph;
    if (r) begin
      m_ph = 0; m_cnt = 0; m_en = 0; m_s1 = 0; m_s2 = 0; m_dv = 0; m_idx = 0; m_val = 0;
      return;
    end
    if (t) begin
      nph   = (m_ph == 5) ? 0 : m_ph + 1;
      m_dv  = (m_ph != 0);
      if (m_ph != 0) begin
        m_idx = m_ph - 1;
        m_val = m_cnt;
      end
      m_ph  = nph;
      m_cnt = 0;
      m_en  = (nph != 0);
    end else begin
      m_dv = 0;
      if (m_en) begin
        if (m_s2) m_en = 0;
        else if (o) begin
          m_cnt++;
          if (m_cnt == ceil_of(m_ph)) m_en = 0;
        end
      end
    end
    m_s2 = m_s1;
    m_s1 = c;
  endtask

  // One cycle: compare at the falling edge, then drive and advance the model.
  task automatic cyc(bit r, bit t, bit o, bit c);
    compare_all();
    model_step(r, t, o, c);
    rst = r; sub_tick = t; osc_pulse = o; cmp_raw = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; sub_tick = 0; osc_pulse = 0; cmp_raw = 0;
    model_step(1, 0, 0, 0);
    @(negedge clk);
    repeat (3) begin
      model_step(1, 0, 0, 0);
      @(posedge clk);
      @(negedge clk);
    end
    check("R10 reset phase", int'(phase_onehot), 1);
    check("R10 reset strobe", int'(digit_valid), 0);
    check("R10 reset count", int'(count_bin), 0);

    // Phase A runs to its ceiling.
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0);
    check("R4 lead ceiling", int'(count_bin), 11);
    check("R7 ladder at 11", int'(ladder_code), 15);
    check("R4 stopped", int'(counting), 0);

    // Phase B runs to the lower ceiling.
    cyc(0, 1, 1, 0);
    check("R8 A strobe", int'(digit_valid), 1);
    check("R8 A value", int'(digit_val), 11);
    check("R8 A index", int'(digit_idx), 0);
    for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0);
    check("R5 rest ceiling", int'(count_bin), 9);

    // Phase C: comparator trip after four pulses.
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1);
    check("R9 trip held count", int'(count_bin), 6);
    check("R9 stopped", int'(counting), 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);

    // D, E, then ZERO with pulses present.
    cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 1, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    check("R6 zero count", int'(count_bin), 0);
    check("R6 zero idle", int'(counting), 0);
    check("R1 zero phase", int'(phase_onehot), 1);

    // Seeded random mix.
    begin
      int cmp_hold;
      cmp_hold = 0;
      for (int i = 0; i < 20000; i++) begin
        bit t, o, c, r;
        t = ($urandom % 18) == 0;
        o = ($urandom % 10) < 7;
        if (cmp_hold > 0) cmp_hold--;
        else if (($urandom % 25) == 0) cmp_hold = 1 + ($urandom % 4);
        c = (cmp_hold > 0);
        r = ($urandom % 3000) == 0;
        cyc(r, t, o, c);
      end
    end
    compare_all();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule